// File: doc/BRIEF.md
# Sixteen-bit serializer / deserializer datapath

This block is the digital core of a serial transceiver. The transmit half takes a parallel word and sends it on a single serial line, one bit per transmit bit clock, with the most significant bit first. The receive half collects bits sampled on the recovered bit clock and delivers them as a parallel word, with the first bit received placed in the most significant position. Each half derives its own word clock by dividing its bit clock by the word width. The transmit word clock paces the upstream phase-align buffer, and a one-cycle read strobe marks the bit-clock cycle in which the next word is taken.

There is no framing or word alignment logic. The word boundary in each direction is fixed by the divider phase, and a synchronous reset puts that phase at zero. Parallel receive data is launched on the falling edge of the receive word clock, so a consumer clocking on the rising edge of that clock sees data that has been stable for half a word period. The phase-locked loops that make the bit clocks are outside the block. Each bit clock arrives as an input.

Top module: `serdes16_core`

## Requirements
- R1: The transmit serial output sends each loaded word with bit 15 in the first bit time and bit 0 in the sixteenth.
- R2: A new transmit word is taken from `tx_word_in` only on the bit-clock edge that ends the cycle in which bit 0 is on the line, so words follow each other with no gap. `tx_word_in` has no effect in the other 15 cycles of a word.
- R3: `tx_word_rd` is high for exactly one bit-clock cycle in every 16, namely the cycle in which the divider phase is 15. The load edge is the rising edge that ends that cycle.
- R4: `tx_word_clk` is the transmit bit clock divided by 16. It is high while the transmit divider phase is 0 to 7 and low while the phase is 8 to 15.
- R5: The first bit sampled after reset, and every sixteenth bit after it, becomes bit 15 of a receive word. The following bits fill bits 14 down to 0.
- R6: A new receive word appears every 16 receive bit times. It is held unchanged between updates, and the first word appears 24 bit-clock edges after reset is released.
- R7: `rx_word_out` changes only in the cycle in which `rx_word_clk` has just gone from high to low.
- R8: `rx_word_clk` is the receive bit clock divided by 16. It is high while the receive divider phase is 0 to 7 and low while the phase is 8 to 15.
- R9: While reset is held and right after it, both divider phases are 0, both word clocks are high, `tx_word_rd` is low, `tx_ser_out` is 0 and `rx_word_out` is 0. The transmitter sends zeros until the first loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_bit_clk | input | 1 | Transmit bit clock |
| tx_rst | input | 1 | Synchronous active-high reset, transmit domain |
| tx_word_in | input | WORD_W | Parallel word offered by the phase-align buffer |
| tx_word_rd | output | 1 | Strobe marking the cycle whose closing edge loads `tx_word_in` |
| tx_word_clk | output | 1 | Transmit bit clock divided by WORD_W |
| tx_ser_out | output | 1 | Serial transmit data, MSB first |
| rx_bit_clk | input | 1 | Recovered receive bit clock |
| rx_rst | input | 1 | Synchronous active-high reset, receive domain |
| rx_ser_in | input | 1 | Recovered serial data, sampled on the rising edge |
| rx_word_out | output | WORD_W | Parallel receive word, first bit in the MSB |
| rx_word_clk | output | 1 | Receive bit clock divided by WORD_W |

## Verification
On every cycle, the assertions check that each word clock moves only at divider phase 0 or the half-word phase and that it is high right after the last-phase marker. They also check that the load strobe is a single-cycle pulse, that the bit on the serial line after a load is the MSB of the word offered at the load, and that the receive word changes only together with a falling receive word clock. The bench scenarios alone can show the full bit order inside a word, the independence from `tx_word_in` between loads, the placement of received bits into the word, the 24-edge receive latency, the end-to-end result of a serial loopback, and re-alignment after a reset in mid-stream.

// File: rtl/serdes16_pkg.sv
`timescale 1ns/1ps
package serdes16_pkg;

  // Registered phase markers that one word divider hands to its datapath.
  typedef struct packed {
    logic word_clk;  // divided clock: high for the first half of a word
    logic at_last;   // divider phase is WORD_W-1 (load / capture cycle)
    logic pre_fall;  // divider phase is WORD_W/2-1 (word clock falls next)
  } wphase_t;

endpackage

// File: rtl/serdes16_word_div.sv
`timescale 1ns/1ps
module serdes16_word_div
  import serdes16_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic    clk,
  input  logic    rst,
  output wphase_t phase_o
);

  localparam int CW   = $clog2(WORD_W);
  localparam int HALF = WORD_W / 2;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF);
  localparam logic [CW-1:0] PRE  = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  wphase_t       ph_q;

  always_comb begin
    if (cnt_q == LAST) cnt_nxt = '0;
    else               cnt_nxt = cnt_q + 1'b1;
  end

  // Markers are decoded from the next count so every output is a flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q         <= '0;
      ph_q.word_clk <= 1'b1;
      ph_q.at_last  <= 1'b0;
      ph_q.pre_fall <= 1'b0;
    end else begin
      cnt_q         <= cnt_nxt;
      ph_q.word_clk <= (cnt_nxt < MID);
      ph_q.at_last  <= (cnt_nxt == LAST);
      ph_q.pre_fall <= (cnt_nxt == PRE);
    end
  end

  assign phase_o = ph_q;

  // R4 R8
  word_clk_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ph_q.word_clk) |-> (cnt_q == '0 || cnt_q == MID));

  // R4 R8
  word_clk_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    ph_q.at_last |=> ph_q.word_clk);

endmodule

// File: rtl/serdes16_tx_shift.sv
`timescale 1ns/1ps
module serdes16_tx_shift
  import serdes16_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  wphase_t           phase_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o,
  output logic              rd_o,
  output logic              wclk_o
);

  logic [WORD_W-1:0] sreg_q;

  // Reload in the cycle that carries bit 0, so the next MSB follows directly.
  always_ff @(posedge clk) begin
    if (rst)                  sreg_q <= '0;
    else if (phase_i.at_last) sreg_q <= word_i;
    else                      sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
  end

  assign ser_o  = sreg_q[WORD_W-1];
  assign rd_o   = phase_i.at_last;
  assign wclk_o = phase_i.word_clk;

  // R1 R2
  msb_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    phase_i.at_last |=> (ser_o == $past(word_i[WORD_W-1])));

  // R3
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_o |=> !rd_o);

  // R4
  tx_clk_fall_chk: assert property (@(posedge clk) disable iff (rst)
    phase_i.pre_fall |=> !wclk_o);

endmodule

// File: rtl/serdes16_rx_shift.sv
`timescale 1ns/1ps
module serdes16_rx_shift
  import serdes16_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  wphase_t           phase_i,
  input  logic              ser_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wclk_o
);

  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      hold_q <= '0;
      word_q <= '0;
    end else begin
      sh_q <= {sh_q[WORD_W-2:0], ser_i};
      // Sixteenth bit of the word completes the capture.
      if (phase_i.at_last)  hold_q <= {sh_q[WORD_W-2:0], ser_i};
      // Launch together with the falling edge of the word clock.
      if (phase_i.pre_fall) word_q <= hold_q;
    end
  end

  assign word_o = word_q;
  assign wclk_o = phase_i.word_clk;

  // R7
  rx_launch_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_q) |-> $fell(phase_i.word_clk));

endmodule

// File: rtl/serdes16_core.sv
`timescale 1ns/1ps
module serdes16_core
  import serdes16_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              tx_bit_clk,
  input  logic              tx_rst,
  input  logic [WORD_W-1:0] tx_word_in,
  output logic              tx_word_rd,
  output logic              tx_word_clk,
  output logic              tx_ser_out,
  input  logic              rx_bit_clk,
  input  logic              rx_rst,
  input  logic              rx_ser_in,
  output logic [WORD_W-1:0] rx_word_out,
  output logic              rx_word_clk
);

  wphase_t tx_phase;
  wphase_t rx_phase;

  serdes16_word_div #(.WORD_W(WORD_W)) u_tx_div (
    .clk     (tx_bit_clk),
    .rst     (tx_rst),
    .phase_o (tx_phase)
  );

  serdes16_tx_shift #(.WORD_W(WORD_W)) u_tx_shift (
    .clk     (tx_bit_clk),
    .rst     (tx_rst),
    .phase_i (tx_phase),
    .word_i  (tx_word_in),
    .ser_o   (tx_ser_out),
    .rd_o    (tx_word_rd),
    .wclk_o  (tx_word_clk)
  );

  serdes16_word_div #(.WORD_W(WORD_W)) u_rx_div (
    .clk     (rx_bit_clk),
    .rst     (rx_rst),
    .phase_o (rx_phase)
  );

  serdes16_rx_shift #(.WORD_W(WORD_W)) u_rx_shift (
    .clk     (rx_bit_clk),
    .rst     (rx_rst),
    .phase_i (rx_phase),
    .ser_i   (rx_ser_in),
    .word_o  (rx_word_out),
    .wclk_o  (rx_word_clk)
  );

endmodule

// File: tb/sim_serdes16_core.sv
`timescale 1ns/1ps
module sim_serdes16_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tx_word_in = 16'h0;
  logic        tx_word_rd, tx_word_clk, tx_ser_out;
  logic        rx_ser_in;
  logic [15:0] rx_word_out;
  logic        rx_word_clk;
  logic        drv_rx = 1'b0;
  logic        loop_en = 1'b0;

  int checks = 0;
  int fails  = 0;
  int n      = 0;

  logic [15:0] txw [8];
  logic [15:0] rxw [8];

  always #4 clk = ~clk;

  assign rx_ser_in = loop_en ? tx_ser_out : drv_rx;

  serdes16_core #(.WORD_W(16)) u0 (
    .tx_bit_clk  (clk),
    .tx_rst      (rst),
    .tx_word_in  (tx_word_in),
    .tx_word_rd  (tx_word_rd),
    .tx_word_clk (tx_word_clk),
    .tx_ser_out  (tx_ser_out),
    .rx_bit_clk  (clk),
    .rx_rst      (rst),
    .rx_ser_in   (rx_ser_in),
    .rx_word_out (rx_word_out),
    .rx_word_clk (rx_word_clk)
  );

  // Bit-clock edges since reset release.
  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  function automatic logic [15:0] tw(int i);
    return (i >= 0 && i < 8) ? txw[i] : 16'h0000;
  endfunction

  function automatic logic [15:0] rw(int i);
    return (i >= 0 && i < 8) ? rxw[i] : 16'h0000;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s n=%0d actual=%h expected=%h", req, n, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R9 state while reset is held
    chk("R9 ser_out", {15'b0, tx_ser_out}, 16'h0);
    chk("R9 rd", {15'b0, tx_word_rd}, 16'h0);
    chk("R9 tx_word_clk", {15'b0, tx_word_clk}, 16'h1);
    chk("R9 rx_word_clk", {15'b0, rx_word_clk}, 16'h1);
    chk("R9 rx_word", rx_word_out, 16'h0);
    rst = 1'b0;
  endtask

  // Drive for the coming edge, then check outputs after it.
  task automatic run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      logic [15:0] w;
      logic [15:0] exp_rx;
      logic        exp_tx;
      logic [15:0] prev_rx;
      logic        prev_clk;
      int          k;
      k = n;
      // R2: junk in every cycle except the load cycle
      tx_word_in = (k % 16 == 15) ? tw(k / 16) : (16'hDEAD ^ 16'(k));
      w = rw(k / 16);
      drv_rx = w[15 - k % 16];
      prev_rx = rx_word_out;
      prev_clk = rx_word_clk;
      @(negedge clk);
      k = n;
      if (k < 16) exp_tx = 1'b0;
      else begin
        w = tw(k / 16 - 1);
        exp_tx = w[15 - k % 16];
      end
      chk("R1 R2 R9 tx bit", {15'b0, tx_ser_out}, {15'b0, exp_tx});
      chk("R3 rd strobe", {15'b0, tx_word_rd}, {15'b0, (k % 16 == 15)});
      chk("R4 tx_word_clk", {15'b0, tx_word_clk}, {15'b0, (k % 16 < 8)});
      chk("R8 rx_word_clk", {15'b0, rx_word_clk}, {15'b0, (k % 16 < 8)});
      if (k < 24) exp_rx = 16'h0;
      else if (loop_en) exp_rx = ((k - 8) / 16 - 1 >= 1) ? tw((k - 8) / 16 - 2) : 16'h0;
      else exp_rx = rw((k - 8) / 16 - 1);
      chk("R5 R6 rx word", rx_word_out, exp_rx);
      if (rx_word_out !== prev_rx)
        chk("R7 rx change on fall", {15'b0, prev_clk & ~rx_word_clk}, 16'h1);
    end
  endtask

  task automatic t_reset_state();
    loop_en = 1'b0;
    for (int i = 0; i < 8; i++) begin txw[i] = 16'h0; rxw[i] = 16'h0; end
    do_reset();
    run(20);
  endtask

  task automatic t_tx_order();
    txw[0] = 16'h8000; txw[1] = 16'h0001; txw[2] = 16'hA5C3; txw[3] = 16'hFFFF;
    txw[4] = 16'h0000; txw[5] = 16'h7FFE; txw[6] = 16'h1234; txw[7] = 16'hC001;
    for (int i = 0; i < 8; i++) rxw[i] = 16'h0;
    loop_en = 1'b0;
    do_reset();
    run(16 * 10);
  endtask

  task automatic t_rx_order();
    rxw[0] = 16'h8000; rxw[1] = 16'h0001; rxw[2] = 16'h5A3C; rxw[3] = 16'hFFFF;
    rxw[4] = 16'h00FF; rxw[5] = 16'hF00F; rxw[6] = 16'h2468; rxw[7] = 16'hACE1;
    for (int i = 0; i < 8; i++) txw[i] = 16'h0;
    loop_en = 1'b0;
    do_reset();
    run(16 * 10);
  endtask

  task automatic t_loopback();
    // R5 R1: serial loopback returns each sent word one word later
    txw[0] = 16'hB00B; txw[1] = 16'h4321; txw[2] = 16'h8001; txw[3] = 16'h6996;
    txw[4] = 16'hFFFE; txw[5] = 16'h0F0F; txw[6] = 16'h1111; txw[7] = 16'hE7E7;
    loop_en = 1'b1;
    do_reset();
    run(16 * 11);
    loop_en = 1'b0;
  endtask

  task automatic t_reset_midrun();
    // R9: reset in mid-word restarts both dividers at phase 0
    txw[0] = 16'hFFFF; txw[1] = 16'hFFFF; rxw[0] = 16'hFFFF; rxw[1] = 16'hFFFF;
    for (int i = 2; i < 8; i++) begin txw[i] = 16'h0; rxw[i] = 16'h0; end
    do_reset();
    run(37);
    txw[0] = 16'h9C3A; txw[1] = 16'h0810; rxw[0] = 16'h3A9C; rxw[1] = 16'h1008;
    do_reset();
    run(16 * 4);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_tx_order();
    t_rx_order();
    t_loopback();
    t_reset_midrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule